// File: doc/BRIEF.md
# Pedestrian Crossing Signal Sequencer

This block is a Moore state machine for a single crossing with one car signal (red, yellow, green) and one pedestrian signal (red, green). The phase lengths differ only because some phases repeat a state. Pedestrians get three consecutive walk steps, cars get two go steps, and one warning step follows. The machine then wraps back to the first walk step. The dark start-up state is used only after reset and after recovery from the unused code.

The state lives in a 3-bit binary register. The machine moves one state on each clock edge where the step qualifier is high. The five lamp outputs are registered, and they are decoded from the same next-state value that loads the state register. As a result, the lamps always match the visible state and no input reaches an output within a cycle. If the register ever holds the unused code, the next edge returns it to the dark state whatever the qualifier is. An integrator drives `step_en` from any slow tick to set the real time per step.

Top module: `tl_ped_crossing`

## Requirements
- R1: While `rst` is high at a rising edge, that edge loads phase 000 and lamps 00000.
- R2: With `step_en` high, each edge advances the phase through the codes 000→001→010→011→100→101→110, and 110 is followed by 001.
- R3: `lamps_o` bit 4 is car red, bit 3 car yellow, bit 2 car green, bit 1 pedestrian red and bit 0 pedestrian green. The lamp values are 00000 in phase 000, 10001 in phases 001/010/011, 00110 in phases 100/101, and 01010 in phase 110.
- R4: The lamps change only at a clock edge, together with the phase. Toggling `step_en` between edges leaves `lamps_o` unchanged.
- R5: With `step_en` low at an edge, the phase and lamps hold their values.
- R6: After phase 000 is left, normal stepping never returns to phase 000, and the phase sequence repeats with a period of exactly 6 steps.
- R7: If the phase register holds the unused code 111, the next edge loads phase 000 with all lamps off, even when `step_en` is low.
- R8: Car green (bit 2) and pedestrian green (bit 0) are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance qualifier; the phase moves only on edges where it is high |
| lamps_o | output | 5 | Registered lamp drives {car red, car yellow, car green, ped red, ped green} |
| phase_o | output | 3 | Current binary phase code |

## Verification
The hardest case to reach is recovery from the unused code 111. The next-state logic can never produce it, so no sequence on the ports can reach it. The bench forces the phase register to 111 between two edges and releases it before the next edge. It then holds `step_en` low and checks that the following edge alone yields phase 000 with every lamp dark. A second hard case is the Moore property. The bench toggles `step_en` in the middle of a cycle and samples the lamps before the next edge to show that they have not moved.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int STATE_W = 3;
  localparam int LAMP_W  = 5;

  typedef enum logic [STATE_W-1:0] {
    ST_DARK  = 3'b000,
    ST_WALK0 = 3'b001,
    ST_WALK1 = 3'b010,
    ST_WALK2 = 3'b011,
    ST_GO0   = 3'b100,
    ST_GO1   = 3'b101,
    ST_WARN  = 3'b110,
    ST_BAD   = 3'b111
  } phase_e;

  // bit 4 car red, 3 car yellow, 2 car green, 1 ped red, 0 ped green
  localparam logic [LAMP_W-1:0] LAMP_OFF   = 5'b00000;
  localparam logic [LAMP_W-1:0] LAMP_WALK  = 5'b10001;
  localparam logic [LAMP_W-1:0] LAMP_DRIVE = 5'b00110;
  localparam logic [LAMP_W-1:0] LAMP_AMBER = 5'b01010;
endpackage

// File: rtl/tl_next_state.sv
module tl_next_state
  import tl_pkg::*;
(
  input  phase_e cur_i,
  output phase_e nxt_o
);
  always_comb begin
    case (cur_i)
      ST_DARK:  nxt_o = ST_WALK0;
      ST_WALK0: nxt_o = ST_WALK1;
      ST_WALK1: nxt_o = ST_WALK2;
      ST_WALK2: nxt_o = ST_GO0;
      ST_GO0:   nxt_o = ST_GO1;
      ST_GO1:   nxt_o = ST_WARN;
      ST_WARN:  nxt_o = ST_WALK0;   // wrap skips the dark state
      default:  nxt_o = ST_DARK;    // unused code recovers
    endcase
  end
endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
  import tl_pkg::*;
(
  input  phase_e             phase_i,
  output logic [LAMP_W-1:0]  lamps_o
);
  always_comb begin
    case (phase_i)
      ST_WALK0, ST_WALK1, ST_WALK2: lamps_o = LAMP_WALK;
      ST_GO0, ST_GO1:               lamps_o = LAMP_DRIVE;
      ST_WARN:                      lamps_o = LAMP_AMBER;
      default:                      lamps_o = LAMP_OFF;
    endcase
  end
endmodule

// File: rtl/tl_ped_crossing.sv
module tl_ped_crossing
  import tl_pkg::*;
#(
  parameter bit STEP_GATED = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_en,
  output logic [LAMP_W-1:0]  lamps_o,
  output logic [STATE_W-1:0] phase_o
);
  phase_e              state_q;
  phase_e              state_nxt;
  phase_e              state_d;
  logic                advance;
  logic [LAMP_W-1:0]   lamp_d;
  logic [LAMP_W-1:0]   lamp_q;

  generate
    if (STEP_GATED) begin : g_gated
      assign advance = step_en;
    end else begin : g_free
      logic unused_step;
      assign unused_step = step_en;
      assign advance     = 1'b1;
    end
  endgenerate

  tl_next_state u_next (
    .cur_i (state_q),
    .nxt_o (state_nxt)
  );

  // recovery from the unused code does not wait for a step
  assign state_d = (advance || state_q == ST_BAD) ? state_nxt : state_q;

  // lamps decoded from the value entering the register so they stay aligned
  tl_lamp_decode u_dec (
    .phase_i (state_d),
    .lamps_o (lamp_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_DARK;
      lamp_q  <= LAMP_OFF;
    end else begin
      state_q <= state_d;
      lamp_q  <= lamp_d;
    end
  end

  assign lamps_o = lamp_q;
  assign phase_o = state_q;
endmodule

// File: rtl/tl_ped_crossing_chk.sv
module tl_ped_crossing_chk (
  input logic       clk,
  input logic       rst,
  input logic       step_en,
  input logic [4:0] lamps_o,
  input logic [2:0] phase_o
);
  // R1
  a_r1_reset_dark: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (phase_o == 3'b000 && lamps_o == 5'b00000));
  // R2
  a_r2_wrap_to_walk: assert property (@(posedge clk) disable iff (rst)
    (step_en && phase_o == 3'b110) |=> phase_o == 3'b001);
  // R3
  a_r3_walk_lamps: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'b001 || phase_o == 3'b010 || phase_o == 3'b011) |-> lamps_o == 5'b10001);
  // R5
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_en && phase_o != 3'b111) |=> $stable(phase_o) && $stable(lamps_o));
  // R7
  a_r7_recover: assert property (@(posedge clk) disable iff (rst)
    phase_o == 3'b111 |=> (phase_o == 3'b000 && lamps_o == 5'b00000));
  // R8
  a_r8_green_excl: assert property (@(posedge clk) disable iff (rst)
    !(lamps_o[2] && lamps_o[0]));
endmodule

bind tl_ped_crossing tl_ped_crossing_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .step_en (step_en),
  .lamps_o (lamps_o),
  .phase_o (phase_o)
);

// File: tb/tb_tl_ped_crossing.sv
module tb_tl_ped_crossing;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic [4:0] lamps_o;
  logic [2:0] phase_o;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  tl_ped_crossing dut (
    .clk(clk), .rst(rst), .step_en(step_en), .lamps_o(lamps_o), .phase_o(phase_o)
  );

  always #10 clk = ~clk;   // 50 MHz

  function automatic logic [2:0] nxt(input logic [2:0] s);
    if (s == 3'b110) return 3'b001;
    if (s == 3'b111) return 3'b000;
    return s + 3'd1;
  endfunction

  function automatic logic [4:0] lamps_for(input logic [2:0] s);
    if (s >= 3'b001 && s <= 3'b011) return 5'b10001;
    if (s == 3'b100 || s == 3'b101) return 5'b00110;
    if (s == 3'b110) return 5'b01010;
    return 5'b00000;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic edge_wait();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; step_en = 1'b1;
    edge_wait();
    edge_wait();
    check("R1 phase", {5'b0, phase_o}, 8'h00);
    check("R1 lamps", {3'b0, lamps_o}, 8'h00);
  endtask

  task automatic t_cycle();
    logic [2:0] exp_s;
    logic [2:0] hist [0:12];
    exp_s = 3'b000;
    rst = 1'b0; step_en = 1'b1;
    for (int k = 0; k < 13; k++) begin
      edge_wait();
      exp_s = nxt(exp_s);
      hist[k] = phase_o;
      check("R2 phase", {5'b0, phase_o}, {5'b0, exp_s});
      check("R3 lamps", {3'b0, lamps_o}, {3'b0, lamps_for(exp_s)});
      check("R8 greens", {7'b0, lamps_o[2] & lamps_o[0]}, 8'h00);
      check("R6 no dark", {7'b0, phase_o == 3'b000}, 8'h00);
      if (k >= 6) check("R6 period", {5'b0, hist[k]}, {5'b0, hist[k-6]});
    end
  endtask

  task automatic t_hold();
    logic [2:0] s0;
    logic [4:0] l0;
    s0 = phase_o; l0 = lamps_o;
    step_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      edge_wait();
      check("R5 phase hold", {5'b0, phase_o}, {5'b0, s0});
      check("R5 lamps hold", {3'b0, lamps_o}, {3'b0, l0});
    end
    step_en = 1'b1;
    #3 check("R4 lamps steady", {3'b0, lamps_o}, {3'b0, l0});
    step_en = 1'b0;
    #3 step_en = 1'b1;
    #2 check("R4 lamps steady", {3'b0, lamps_o}, {3'b0, l0});
    step_en = 1'b0;
    edge_wait();
    check("R4 phase", {5'b0, phase_o}, {5'b0, s0});
  endtask

  task automatic t_bad();
    @(negedge clk);
    rst = 1'b1; step_en = 1'b1;
    edge_wait();
    rst = 1'b0;
    edge_wait();
    edge_wait();
    check("R2 pre", {5'b0, phase_o}, 8'h02);
    force dut.state_q = tl_pkg::ST_BAD;
    #1 release dut.state_q;
    step_en = 1'b0;
    #1 check("R7 bad seen", {5'b0, phase_o}, 8'h07);
    edge_wait();
    check("R7 phase", {5'b0, phase_o}, 8'h00);
    check("R7 lamps", {3'b0, lamps_o}, 8'h00);
    step_en = 1'b1;
    edge_wait();
    check("R2 restart", {5'b0, phase_o}, 8'h01);
    check("R3 restart", {3'b0, lamps_o}, 8'h11);
  endtask

  initial begin
    t_reset();
    t_cycle();
    t_hold();
    t_bad();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule